// File: doc/BRIEF.md
# Configurable CRC Engine

A register-mapped checksum engine that keeps a running cyclic-redundancy remainder of 16 or 32 bits and uses a generator polynomial that software programs. Software first picks the width and the transposition options in the control register and writes the polynomial. With the seed bit set, it writes the start value through the data register. It then clears the seed bit and streams the message through the same data register. Each write may be a byte, a half-word or a word, and each write is folded into the remainder in a single clock.

On readback, the data register shows the remainder with an optional final complement and an optional output transposition applied. In 16-bit mode, an output transposition that reorders bytes moves the result into the upper half of the 32-bit read. Input transposition is set separately from output transposition. Together with the mixed write sizes, this lets software feed packed little-endian or big-endian buffers and still get the same checksum.

Top module: `crc_engine`

## Requirements
- R1: After reset, the data, polynomial and control registers all read as zero.
- R2: `reg_addr` 0 selects data, 1 selects polynomial and 2 selects control; address 3 reads zero. The polynomial reads back all 32 bits. The control register reads back in bits 6:0, laid out as bit0 width (1 = 32-bit), bit1 seed mode, bits 3:2 input transposition, bits 5:4 output transposition and bit6 complement.
- R3: While seed mode is set, a data write loads the remainder with the written value without folding. The value is masked to the access size (`wr_size` 0 byte, 1 half, 2 or 3 word) and, in 16-bit mode, to 16 bits.
- R4: While seed mode is clear, a data write folds the low 8, 16 or 32 bits of `wr_data`, most significant bit first. Writes of different sizes continue one running remainder, and the result can be read in the cycle after the last write. Polynomial 0x1021 with seed 0xFFFF gives 0x29B1 for the string "123456789", fed as single bytes or in mixed pieces.
- R5: In 16-bit mode only the low 16 bits of the polynomial take part in folding.
- R6: Input transposition applies to each write before folding. 00 leaves the data as is, 01 reverses the bits within each byte, 10 reverses the whole access, and 11 reverses the byte order of the access.
- R7: In 32-bit mode the output transposition uses the same encoding over the 32-bit result. Polynomial 0x04C11DB7, seed 0 and complement on give 0x765E7680, 0x80765E76 with 11, and 0x6E7A6E01 with 01.
- R8: In 16-bit mode the result is placed in bits 15:0 with output transposition 00 or 01. It appears in bits 31:16 with 10 or 11, and the other half reads zero.
- R9: The complement bit inverts only the active result width, and it is applied before output transposition.
- R10: Writes to the polynomial or control register, and cycles without a write, leave the remainder unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select for writes and reads |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| wr_data | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Combinational read data for `reg_addr` |

## Verification
The case hardest to reach from the ports is a single message split across writes of different sizes while a byte-reordering input transposition is active. Here the order of the bytes inside each access decides the checksum. The stimulus packs the standard check string into word, byte and half-word pieces, using the endianness that each transposition mode expects. The same catalogue value must then come out as it does for byte-at-a-time feeding. Output placement is exercised by rewriting only the control register after a finished message and reading the held remainder under every output mode.

// File: rtl/crc_eng_pkg.sv
`timescale 1ns/1ps
package crc_eng_pkg;
    parameter int DW     = 32;
    parameter int NARROW = 16;
    localparam int NBYTES = DW / 8;
    localparam logic [DW-1:0] NARROW_MASK = {{(DW-NARROW){1'b0}}, {NARROW{1'b1}}};

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_POLY = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef enum logic [1:0] {
        XP_NONE  = 2'b00,
        XP_BITS  = 2'b01,
        XP_BOTH  = 2'b10,
        XP_BYTES = 2'b11
    } xpose_e;

    typedef struct packed {
        logic       comp;
        xpose_e     out_x;
        xpose_e     in_x;
        logic       seed;
        logic       wide;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t          ctrl;
        logic [DW-1:0]  poly;
        logic [DW-1:0]  rem;
    } state_t;

    function automatic int size_bytes(logic [1:0] sz);
        case (sz)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return NBYTES;
        endcase
    endfunction

    function automatic logic [DW-1:0] size_mask(logic [1:0] sz);
        logic [DW-1:0] m;
        m = '0;
        for (int k = 0; k < NBYTES; k++)
            if (k < size_bytes(sz)) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    // Transposes the low nb bytes of v according to mode.
    function automatic logic [DW-1:0] xpose(logic [DW-1:0] v, xpose_e mode, int nb);
        logic [DW-1:0] b;
        logic [DW-1:0] r;
        b = v;
        if (mode == XP_BITS || mode == XP_BOTH)
            for (int k = 0; k < NBYTES; k++)
                for (int j = 0; j < 8; j++)
                    b[8*k + j] = v[8*k + 7 - j];
        r = b;
        if (mode == XP_BOTH || mode == XP_BYTES)
            for (int k = 0; k < NBYTES; k++)
                if (k < nb) r[8*k +: 8] = b[8*(nb-1-k) +: 8];
        return r;
    endfunction
endpackage

// File: rtl/crc_fold.sv
`timescale 1ns/1ps
module crc_fold
    import crc_eng_pkg::*;
(
    input  logic [DW-1:0] rem_in,
    input  logic [DW-1:0] poly,
    input  logic [DW-1:0] data,
    input  logic [3:0]    nbytes,
    input  logic          wide,
    output logic [DW-1:0] rem_out
);
    logic [DW-1:0] r;
    logic [DW-1:0] p;
    logic          fb;
    int            top;
    int            nbits;

    always_comb begin
        p     = wide ? poly : (poly & NARROW_MASK);
        top   = wide ? DW - 1 : NARROW - 1;
        nbits = 8 * int'(nbytes);
        r     = rem_in;
        fb    = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (i < nbits) begin
                fb = r[top] ^ data[i];
                r  = {r[DW-2:0], 1'b0};
                if (fb) r = r ^ p;
            end
        end
        if (!wide) r = r & NARROW_MASK;
        rem_out = r;
    end
endmodule

// File: rtl/crc_out_stage.sv
`timescale 1ns/1ps
module crc_out_stage
    import crc_eng_pkg::*;
(
    input  logic [DW-1:0] rem,
    input  logic          wide,
    input  logic          comp,
    input  xpose_e        out_x,
    output logic [DW-1:0] result
);
    logic [DW-1:0] active_mask;
    logic [DW-1:0] val;

    always_comb begin
        active_mask = wide ? '1 : NARROW_MASK;
        val         = rem & active_mask;
        if (comp) val = val ^ active_mask;
        result = xpose(val, out_x, NBYTES);
    end
endmodule

// File: rtl/crc_engine.sv
`timescale 1ns/1ps
module crc_engine
    import crc_eng_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          wr_en,
    input  logic [1:0]    wr_size,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    state_t        st_d, st_q;
    logic [DW-1:0] chunk;
    logic [DW-1:0] chunk_x;
    logic [3:0]    nbytes;
    logic [DW-1:0] folded;
    logic [DW-1:0] result;

    // Views used by the bound checker.
    logic [DW-1:0]     rem_q;
    logic [CTRL_W-1:0] ctrl_bits_q;
    assign rem_q       = st_q.rem;
    assign ctrl_bits_q = st_q.ctrl;

    always_comb begin
        nbytes  = 4'(size_bytes(wr_size));
        chunk   = wr_data & size_mask(wr_size);
        chunk_x = xpose(chunk, st_q.ctrl.in_x, size_bytes(wr_size));
    end

    crc_fold i_fold (
        .rem_in  (st_q.rem),
        .poly    (st_q.poly),
        .data    (chunk_x),
        .nbytes  (nbytes),
        .wide    (st_q.ctrl.wide),
        .rem_out (folded)
    );

    crc_out_stage i_out (
        .rem    (st_q.rem),
        .wide   (st_q.ctrl.wide),
        .comp   (st_q.ctrl.comp),
        .out_x  (st_q.ctrl.out_x),
        .result (result)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_addr)
                ADDR_DATA: begin
                    if (st_q.ctrl.seed)
                        st_d.rem = st_q.ctrl.wide ? chunk : (chunk & NARROW_MASK);
                    else
                        st_d.rem = folded;
                end
                ADDR_POLY: st_d.poly = wr_data;
                ADDR_CTRL: st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_DATA: rd_data = result;
            ADDR_POLY: rd_data = st_q.poly;
            ADDR_CTRL: rd_data = {{(DW-CTRL_W){1'b0}}, st_q.ctrl};
            default:   rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/crc_engine_chk.sv
`timescale 1ns/1ps
module crc_engine_chk
    import crc_eng_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic              wr_en,
    input logic [1:0]        wr_size,
    input logic [DW-1:0]     wr_data,
    input logic [DW-1:0]     rd_data,
    input logic [DW-1:0]     rem_q,
    input logic [CTRL_W-1:0] ctrl_bits_q
);
    ctrl_t c;
    assign c = ctrl_t'(ctrl_bits_q);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rem_q));

    // R10
    side_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr != ADDR_DATA) |=> $stable(rem_q));

    // R3
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_DATA && c.seed && c.wide && wr_size[1])
        |=> rem_q == $past(wr_data));

    // R8
    upper_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_DATA && !c.wide && c.out_x[1]) |-> rd_data[NARROW-1:0] == '0);

    // R8
    lower_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_DATA && !c.wide && !c.out_x[1]) |-> rd_data[DW-1:NARROW] == '0);
endmodule

bind crc_engine crc_engine_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .wr_en       (wr_en),
    .wr_size     (wr_size),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .rem_q       (rem_q),
    .ctrl_bits_q (ctrl_bits_q)
);

// File: tb/test_crc_engine.sv
`timescale 1ns/1ps
module test_crc_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd2;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    crc_engine i_crc_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_size(wr_size), .wr_data(wr_data), .rd_data(rd_data)
    );

    localparam logic [1:0] A_DATA = 2'd0, A_POLY = 2'd1, A_CTRL = 2'd2;
    localparam logic [1:0] S_B = 2'd0, S_H = 2'd1, S_W = 2'd2;

    function automatic logic [31:0] cw(bit wide, bit seed, logic [1:0] inx,
                                       logic [1:0] outx, bit comp);
        return {25'd0, comp, outx, inx, seed, wide};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [1:0] sz, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; wr_size = sz; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; wr_en = 1'b0;
        #1 v = rd_data;
    endtask

    task automatic setup(logic [31:0] poly, logic [31:0] seed, bit wide,
                         logic [1:0] inx, logic [1:0] outx, bit comp);
        wr(A_POLY, S_W, poly);
        wr(A_CTRL, S_W, cw(wide, 1, inx, outx, comp));
        wr(A_DATA, S_W, seed);
        wr(A_CTRL, S_W, cw(wide, 0, inx, outx, comp));
    endtask

    task automatic feed_bytes(string s);
        for (int i = 0; i < s.len(); i++) wr(A_DATA, S_B, {24'd0, s[i]});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_DATA, v); chk("R1 data", v, 32'h0);
        rd(A_POLY, v); chk("R1 poly", v, 32'h0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_POLY, S_W, 32'hDEADBEEF);
        rd(A_POLY, v); chk("R2 poly", v, 32'hDEADBEEF);
        wr(A_CTRL, S_W, 32'hFFFF_FF5A);
        rd(A_CTRL, v); chk("R2 ctrl", v, 32'h0000_005A);
        rd(2'd3, v);   chk("R2 addr3", v, 32'h0);
    endtask

    task automatic t_seed();
        logic [31:0] v;
        wr(A_CTRL, S_W, cw(1, 1, 2'b00, 2'b00, 0));
        wr(A_DATA, S_B, 32'h1234_56A5);
        rd(A_DATA, v); chk("R3 byte seed", v, 32'h0000_00A5);
        wr(A_DATA, S_H, 32'h1234_ABCD);
        rd(A_DATA, v); chk("R3 half seed", v, 32'h0000_ABCD);
        wr(A_DATA, S_W, 32'hCAFE_F00D);
        rd(A_DATA, v); chk("R3 word seed", v, 32'hCAFE_F00D);
        wr(A_CTRL, S_W, cw(0, 1, 2'b00, 2'b00, 0));
        wr(A_DATA, S_W, 32'hDEAD_BEEF);
        rd(A_DATA, v); chk("R3 narrow seed", v, 32'h0000_BEEF);
    endtask

    task automatic t_ccitt_bytes();
        logic [31:0] v;
        setup(32'h0000_1021, 32'hFFFF, 0, 2'b00, 2'b00, 0);
        feed_bytes("123456789");
        rd(A_DATA, v); chk("R4 bytes 0x29B1", v, 32'h0000_29B1);
        // R10: side writes and idle cycles keep the remainder
        wr(A_POLY, S_W, 32'h0000_8005);
        rd(A_DATA, v); chk("R10 poly write", v, 32'h0000_29B1);
        wr(A_CTRL, S_W, cw(0, 0, 2'b00, 2'b00, 0));
        repeat (5) @(negedge clk);
        rd(A_DATA, v); chk("R10 ctrl write idle", v, 32'h0000_29B1);
        // R8 / R9: output placement with held remainder
        wr(A_CTRL, S_W, cw(0, 0, 2'b00, 2'b01, 0));
        rd(A_DATA, v); chk("R8 bits low", v, 32'h0000_948D);
        wr(A_CTRL, S_W, cw(0, 0, 2'b00, 2'b11, 0));
        rd(A_DATA, v); chk("R8 bytes high", v, 32'hB129_0000);
        wr(A_CTRL, S_W, cw(0, 0, 2'b00, 2'b10, 0));
        rd(A_DATA, v); chk("R8 both high", v, 32'h8D94_0000);
        wr(A_CTRL, S_W, cw(0, 0, 2'b00, 2'b11, 1));
        rd(A_DATA, v); chk("R9 narrow comp", v, 32'h4ED6_0000);
    endtask

    task automatic t_ccitt_mixed();
        logic [31:0] v;
        // R5: upper polynomial bits are junk in 16-bit mode
        setup(32'hABCD_1021, 32'hFFFF, 0, 2'b00, 2'b00, 0);
        wr(A_DATA, S_W, 32'h3132_3334);
        wr(A_DATA, S_B, 32'h0000_0035);
        wr(A_DATA, S_H, 32'h0000_3637);
        wr(A_DATA, S_H, 32'h0000_3839);
        rd(A_DATA, v); chk("R4 R5 mixed big-endian", v, 32'h0000_29B1);
        // R6: byte-order reversal lets little-endian pieces give the same sum
        setup(32'h0000_1021, 32'hFFFF, 0, 2'b11, 2'b00, 0);
        wr(A_DATA, S_W, 32'h3433_3231);
        wr(A_DATA, S_B, 32'h0000_0035);
        wr(A_DATA, S_H, 32'h0000_3736);
        wr(A_DATA, S_H, 32'h0000_3938);
        rd(A_DATA, v); chk("R6 byte swap in", v, 32'h0000_29B1);
    endtask

    task automatic t_posix();
        logic [31:0] v;
        setup(32'h04C1_1DB7, 32'h0, 1, 2'b00, 2'b00, 1);
        feed_bytes("123456789");
        rd(A_DATA, v); chk("R4 R7 posix", v, 32'h765E_7680);
        wr(A_CTRL, S_W, cw(1, 0, 2'b00, 2'b11, 1));
        rd(A_DATA, v); chk("R7 bytes out", v, 32'h8076_5E76);
        wr(A_CTRL, S_W, cw(1, 0, 2'b00, 2'b01, 1));
        rd(A_DATA, v); chk("R7 bits out", v, 32'h6E7A_6E01);
        wr(A_CTRL, S_W, cw(1, 0, 2'b00, 2'b00, 0));
        rd(A_DATA, v); chk("R9 no comp", v, 32'h89A1_897F);
    endtask

    task automatic t_reflected16();
        logic [31:0] v;
        setup(32'h0000_1021, 32'h0, 0, 2'b01, 2'b10, 0);
        feed_bytes("123456789");
        rd(A_DATA, v); chk("R6 R8 reflected 0x2189", v, 32'h2189_0000);
        setup(32'h0000_8005, 32'h0, 0, 2'b10, 2'b10, 1);
        feed_bytes("123456789");
        rd(A_DATA, v); chk("R6 R9 reflected comp 0x44C2", v, 32'h44C2_0000);
    endtask

    task automatic t_reflected32();
        logic [31:0] v;
        setup(32'h04C1_1DB7, 32'hFFFF_FFFF, 1, 2'b10, 2'b10, 1);
        wr(A_DATA, S_W, 32'h3433_3231);
        wr(A_DATA, S_H, 32'h0000_3635);
        wr(A_DATA, S_B, 32'h0000_0037);
        wr(A_DATA, S_H, 32'h0000_3938);
        rd(A_DATA, v); chk("R4 R6 mixed reflected", v, 32'hCBF4_3926);
        setup(32'h1EDC_6F41, 32'hFFFF_FFFF, 1, 2'b10, 2'b10, 1);
        feed_bytes("123456789");
        rd(A_DATA, v); chk("R6 R7 other poly", v, 32'hE306_9283);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_seed();
        t_ccitt_bytes();
        t_ccitt_mixed();
        t_posix();
        t_reflected16();
        t_reflected32();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule